// File: doc/BRIEF.md
# Display power-up reset sequencer

This block brings a small command-driven LCD controller out of power-off. A start pulse turns on the panel supply. The block then runs the full reset, or it skips the reset when the panel reports that it is already running. The full reset is a timed low pulse on the panel reset line, a hold-off wait, a parameterless soft-reset command and a final settling wait. Every wait is measured in clock cycles, computed at elaboration from the clock frequency parameter, and each count is rounded up.

The block does not drive the serial wire. A separate command engine does that. This block places one request at a time on a valid/acknowledge handshake: an opcode plus a flag that marks a one-byte read. The engine answers in the acknowledge cycle with a response byte and an error flag. In conditional mode the block first reads the panel's power-mode byte. If the reset and the soft-reset wait are skipped, the block reports an already-on result. A failed soft-reset command turns the supply off and raises an error. A build option says whether a panel reset line exists. That option decides whether the pulse is generated and how long the block waits after the soft reset.

Top module: `lcd_pwrup_seq`

## Requirements
- R1: `supply_en_o` is high before the first request and before any low level on `panel_rst_n_o`. After a successful run it stays high.
- R2: With a reset line (`HAS_HW_RESET`=1), the full path drives `panel_rst_n_o` low for exactly ceil(`CLK_HZ`·`RST_LOW_US`/10^6) cycles. The default pulse is 20 us.
- R3: After the pulse ends, the line stays high for ceil(`CLK_HZ`·`RST_HOLD_US`/10^6) cycles (default 120 ms) before the soft-reset request appears.
- R4: The soft-reset request carries opcode `OP_SOFT_RST` (default 0x01) with `req_is_read_o`=0 and has no parameters.
- R5: After the soft-reset acknowledge, the block waits a settling time and then raises `done_o` with `on_already_o`=0. The settling time is 5 ms (`SR_WAIT_HW_US`) with a reset line and 120 ms (`SR_WAIT_NR_US`) without one. Without a reset line, `panel_rst_n_o` stays high at all times.
- R6: In conditional mode (`cond_i`=1 at start) the first request is opcode `OP_GET_PWR` (default 0x0A) with `req_is_read_o`=1. The response byte is ANDed with 0x7C (clearing bits 0, 1 and 7) and compared with 0x1C.
- R7: A clean read whose masked byte equals 0x1C ends the run with `done_o`=1 and `on_already_o`=1. No reset pulse and no soft-reset request follow.
- R8: A read that returns `req_err_i`=1, or a masked byte other than 0x1C, continues into the full reset path. Two requests are made in total.
- R9: A soft-reset acknowledge with `req_err_i`=1 drops `supply_en_o`, raises `err_o` and leaves `done_o` low.
- R10: A start pulse while `busy_o` is high has no effect: no restart, no extra pulse and no extra request.
- R11: After reset: `supply_en_o`, `req_valid_o`, `busy_o`, `done_o`, `on_already_o` and `err_o` are 0, and `panel_rst_n_o` is 1. A start clears the previous result flags.
- R12: `req_valid_o` stays high with stable `req_op_o` and `req_is_read_o` until the cycle in which `req_ack_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| cond_i | input | 1 | Sampled at start: 1 checks the power-mode byte first |
| req_valid_o | output | 1 | Request to the command engine |
| req_op_o | output | CMD_W | Request opcode |
| req_is_read_o | output | 1 | Request is a one-byte read |
| req_ack_i | input | 1 | Engine finished the request this cycle |
| req_err_i | input | 1 | Request failed, valid with the acknowledge |
| rsp_data_i | input | CMD_W | Read byte, valid with the acknowledge |
| supply_en_o | output | 1 | Panel supply enable |
| panel_rst_n_o | output | 1 | Panel reset line, active low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last run finished successfully |
| on_already_o | output | 1 | Last run found the panel running and skipped the reset |
| err_o | output | 1 | Last run failed on the soft-reset command |

## Verification
The hardest condition to reach from the ports is a power-mode byte whose ignored bits are set. A reset skip must follow it. A near miss, with one extra or one missing checked bit, must lead to the full path. The vector table makes the bench's command responder return chosen bytes (0x9C, 0x1F, 0x18, 0x3C) and chosen error flags, then counts the accepted requests for each run. A second instance, built without a reset line, and a start pulse injected during the 120 ms hold-off cover the remaining corner cases.

// File: rtl/lcd_pwrup_pkg.sv
package lcd_pwrup_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PWR,
      S_RD,
      S_RLOW,
      S_RREL,
      S_SR,
      S_SWAIT
   } seq_state_e;

   // microseconds to clock cycles, rounded up
   function automatic longint us_to_cyc(input longint hz, input longint us);
      return (hz * us + 64'd999999) / 64'd1000000;
   endfunction

endpackage

// File: rtl/lcd_pwrup_timer.sv
module lcd_pwrup_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lcd_pwrup_pmchk.sv
module lcd_pwrup_pmchk #(
   parameter int               DW    = 8,
   parameter logic [DW-1:0]    MASK  = 8'h7C,
   parameter logic [DW-1:0]    MATCH = 8'h1C
) (
   input  logic [DW-1:0] data_i,
   output logic          on_o
);

   assign on_o = ((data_i & MASK) == MATCH);

endmodule

// File: rtl/lcd_pwrup_seq.sv
module lcd_pwrup_seq
   import lcd_pwrup_pkg::*;
#(
   parameter longint          CLK_HZ        = 50_000_000,
   parameter bit              HAS_HW_RESET  = 1'b1,
   parameter longint          RST_LOW_US    = 20,
   parameter longint          RST_HOLD_US   = 120_000,
   parameter longint          SR_WAIT_HW_US = 5_000,
   parameter longint          SR_WAIT_NR_US = 120_000,
   parameter int              CMD_W         = 8,
   parameter logic [CMD_W-1:0] OP_SOFT_RST  = 8'h01,
   parameter logic [CMD_W-1:0] OP_GET_PWR   = 8'h0A,
   parameter logic [CMD_W-1:0] PM_MASK      = 8'h7C,
   parameter logic [CMD_W-1:0] PM_MATCH     = 8'h1C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cond_i,
   output logic             req_valid_o,
   output logic [CMD_W-1:0] req_op_o,
   output logic             req_is_read_o,
   input  logic             req_ack_i,
   input  logic             req_err_i,
   input  logic [CMD_W-1:0] rsp_data_i,
   output logic             supply_en_o,
   output logic             panel_rst_n_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             on_already_o,
   output logic             err_o
);

   localparam longint LOW_CYC  = us_to_cyc(CLK_HZ, RST_LOW_US);
   localparam longint HOLD_CYC = us_to_cyc(CLK_HZ, RST_HOLD_US);
   localparam longint POST_CYC = HAS_HW_RESET ? us_to_cyc(CLK_HZ, SR_WAIT_HW_US)
                                              : us_to_cyc(CLK_HZ, SR_WAIT_NR_US);
   localparam longint MAX_A    = (LOW_CYC > HOLD_CYC) ? LOW_CYC : HOLD_CYC;
   localparam longint MAX_CYC  = (MAX_A > POST_CYC) ? MAX_A : POST_CYC;
   localparam int     CNT_W    = $clog2(MAX_CYC + 1);

   if (CLK_HZ < 1) begin : g_bad_clk
      $error("CLK_HZ must be positive");
   end
   if (LOW_CYC < 1 || HOLD_CYC < 1 || POST_CYC < 1) begin : g_bad_time
      $error("every wait must last at least one cycle");
   end
   if (CMD_W < 8) begin : g_bad_width
      $error("CMD_W must be at least 8");
   end
   if (OP_SOFT_RST == OP_GET_PWR) begin : g_bad_ops
      $error("soft-reset and power-mode opcodes must differ");
   end

   seq_state_e       state_q, state_d;
   logic             cond_q;
   logic             supply_q, done_q, on_q, err_q;
   logic             tmr_ld, tmr_zero;
   logic [CNT_W-1:0] tmr_val;
   logic             pm_on;
   logic             fin_ok, fin_on, fin_err;

   lcd_pwrup_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_ld),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   lcd_pwrup_pmchk #(.DW(CMD_W), .MASK(PM_MASK), .MATCH(PM_MATCH)) u_pm (
      .data_i (rsp_data_i),
      .on_o   (pm_on)
   );

   always_comb begin
      state_d = state_q;
      tmr_ld  = 1'b0;
      tmr_val = '0;
      fin_ok  = 1'b0;
      fin_on  = 1'b0;
      fin_err = 1'b0;
      unique case (state_q)
         S_IDLE:  if (start_i) state_d = S_PWR;
         S_PWR: begin
            if (cond_q) begin
               state_d = S_RD;
            end else if (HAS_HW_RESET) begin
               state_d = S_RLOW;
               tmr_ld  = 1'b1;
               tmr_val = CNT_W'(LOW_CYC - 1);
            end else begin
               state_d = S_SR;
            end
         end
         S_RD: begin
            if (req_ack_i) begin
               if (!req_err_i && pm_on) begin
                  state_d = S_IDLE;
                  fin_ok  = 1'b1;
                  fin_on  = 1'b1;
               end else if (HAS_HW_RESET) begin
                  state_d = S_RLOW;
                  tmr_ld  = 1'b1;
                  tmr_val = CNT_W'(LOW_CYC - 1);
               end else begin
                  state_d = S_SR;
               end
            end
         end
         S_RLOW: begin
            if (tmr_zero) begin
               state_d = S_RREL;
               tmr_ld  = 1'b1;
               tmr_val = CNT_W'(HOLD_CYC - 1);
            end
         end
         S_RREL:  if (tmr_zero) state_d = S_SR;
         S_SR: begin
            if (req_ack_i) begin
               if (req_err_i) begin
                  state_d = S_IDLE;
                  fin_err = 1'b1;
               end else begin
                  state_d = S_SWAIT;
                  tmr_ld  = 1'b1;
                  tmr_val = CNT_W'(POST_CYC - 1);
               end
            end
         end
         S_SWAIT: begin
            if (tmr_zero) begin
               state_d = S_IDLE;
               fin_ok  = 1'b1;
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         cond_q   <= 1'b0;
         supply_q <= 1'b0;
         done_q   <= 1'b0;
         on_q     <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == S_IDLE && start_i) begin
            cond_q   <= cond_i;
            supply_q <= 1'b1;
            done_q   <= 1'b0;
            on_q     <= 1'b0;
            err_q    <= 1'b0;
         end
         if (fin_ok) begin
            done_q <= 1'b1;
            on_q   <= fin_on;
         end
         if (fin_err) begin
            err_q    <= 1'b1;
            supply_q <= 1'b0;
         end
      end
   end

   if (HAS_HW_RESET) begin : g_rst_line
      assign panel_rst_n_o = (state_q != S_RLOW);
   end else begin : g_no_rst_line
      assign panel_rst_n_o = 1'b1;
   end

   assign req_valid_o   = (state_q == S_RD) || (state_q == S_SR);
   assign req_is_read_o = (state_q == S_RD);
   assign req_op_o      = (state_q == S_RD) ? OP_GET_PWR : OP_SOFT_RST;
   assign supply_en_o   = supply_q;
   assign busy_o        = (state_q != S_IDLE);
   assign done_o        = done_q;
   assign on_already_o  = on_q;
   assign err_o         = err_q;

endmodule

// File: rtl/lcd_pwrup_chk.sv
module lcd_pwrup_chk #(
   parameter int CMD_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid_o,
   input logic [CMD_W-1:0] req_op_o,
   input logic             req_is_read_o,
   input logic             req_ack_i,
   input logic             supply_en_o,
   input logic             panel_rst_n_o,
   input logic             busy_o,
   input logic             done_o,
   input logic             on_already_o,
   input logic             err_o
);

   AST_REQ_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> supply_en_o); // R1

   AST_PULSE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      !panel_rst_n_o |-> supply_en_o && busy_o); // R1

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o && !req_ack_i |=> req_valid_o && $stable(req_op_o)
                                    && $stable(req_is_read_o)); // R12

   AST_ERR_NO_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !supply_en_o && !done_o); // R9

   AST_ON_MEANS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      on_already_o |-> done_o); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !req_valid_o && panel_rst_n_o); // R11

endmodule

bind lcd_pwrup_seq lcd_pwrup_chk #(.CMD_W(CMD_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid_o   (req_valid_o),
   .req_op_o      (req_op_o),
   .req_is_read_o (req_is_read_o),
   .req_ack_i     (req_ack_i),
   .supply_en_o   (supply_en_o),
   .panel_rst_n_o (panel_rst_n_o),
   .busy_o        (busy_o),
   .done_o        (done_o),
   .on_already_o  (on_already_o),
   .err_o         (err_o)
);

// File: tb/lcd_pwrup_seq_tb.sv
module lcd_pwrup_seq_tb;

   localparam longint CLK_HZ   = 100_000;
   localparam int     L_CYC    = 2;      // 20 us
   localparam int     H_CYC    = 12000;  // 120 ms
   localparam int     P_HW     = 500;    // 5 ms
   localparam int     P_NR     = 12000;  // 120 ms

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;

   // responder configuration
   logic       cfg_rd_err = 1'b0;
   logic [7:0] cfg_rd_data = 8'h00;
   logic       cfg_sr_err = 1'b0;

   // HW-reset instance
   logic       start_a = 1'b0, cond_a = 1'b0;
   logic       rv_a, rr_a, sup_a, prn_a, busy_a, done_a, on_a, err_a;
   logic [7:0] op_a;
   logic       ack_a = 1'b0, aerr_a = 1'b0;
   logic [7:0] adat_a = 8'h00;

   lcd_pwrup_seq #(.CLK_HZ(CLK_HZ), .HAS_HW_RESET(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_a), .cond_i(cond_a),
      .req_valid_o(rv_a), .req_op_o(op_a), .req_is_read_o(rr_a),
      .req_ack_i(ack_a), .req_err_i(aerr_a), .rsp_data_i(adat_a),
      .supply_en_o(sup_a), .panel_rst_n_o(prn_a), .busy_o(busy_a),
      .done_o(done_a), .on_already_o(on_a), .err_o(err_a)
   );

   // no-reset-line instance
   logic       start_b = 1'b0;
   logic       rv_b, rr_b, sup_b, prn_b, busy_b, done_b, on_b, err_b;
   logic [7:0] op_b;
   logic       ack_b = 1'b0, aerr_b = 1'b0;
   logic [7:0] adat_b = 8'h00;

   lcd_pwrup_seq #(.CLK_HZ(CLK_HZ), .HAS_HW_RESET(1'b0)) u_dut_nr (
      .clk(clk), .rst_n(rst_n), .start_i(start_b), .cond_i(1'b0),
      .req_valid_o(rv_b), .req_op_o(op_b), .req_is_read_o(rr_b),
      .req_ack_i(ack_b), .req_err_i(aerr_b), .rsp_data_i(adat_b),
      .supply_en_o(sup_b), .panel_rst_n_o(prn_b), .busy_o(busy_b),
      .done_o(done_b), .on_already_o(on_b), .err_o(err_b)
   );

   // monitors and responders
   logic clr = 1'b0;
   int   nreq_a, opbad_a, supbad_a, low_a, hold_a, post_a;
   logic seenlow_a, seensr_a;
   int   nreq_b, opbad_b, low_b, post_b;
   logic seensr_b;

   always @(posedge clk) begin
      ack_a <= rv_a && !ack_a;
      ack_b <= rv_b && !ack_b;
      if (rv_a && !ack_a) begin
         adat_a <= cfg_rd_data;
         aerr_a <= rr_a ? cfg_rd_err : cfg_sr_err;
      end
      if (rv_b && !ack_b) begin
         adat_b <= cfg_rd_data;
         aerr_b <= rr_b ? cfg_rd_err : cfg_sr_err;
      end
      if (clr) begin
         nreq_a <= 0; opbad_a <= 0; supbad_a <= 0; low_a <= 0; hold_a <= 0;
         post_a <= 0; seenlow_a <= 1'b0; seensr_a <= 1'b0;
         nreq_b <= 0; opbad_b <= 0; low_b <= 0; post_b <= 0; seensr_b <= 1'b0;
      end else begin
         if (rv_a && ack_a) begin
            nreq_a <= nreq_a + 1;
            if (rr_a ? (op_a != 8'h0A) : (op_a != 8'h01)) opbad_a <= opbad_a + 1;
         end
         if ((rv_a || !prn_a) && !sup_a) supbad_a <= supbad_a + 1;
         if (!prn_a) begin low_a <= low_a + 1; seenlow_a <= 1'b1; end
         if (prn_a && seenlow_a && !seensr_a && busy_a && !rv_a) hold_a <= hold_a + 1;
         if (rv_a && !rr_a) seensr_a <= 1'b1;
         if (seensr_a && busy_a && !rv_a) post_a <= post_a + 1;
         if (rv_b && ack_b) begin
            nreq_b <= nreq_b + 1;
            if (rr_b || op_b != 8'h01) opbad_b <= opbad_b + 1;
         end
         if (!prn_b) low_b <= low_b + 1;
         if (rv_b && !rr_b) seensr_b <= 1'b1;
         if (seensr_b && busy_b && !rv_b) post_b <= post_b + 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_idle_a();
      int t = 0;
      @(negedge clk);
      while (busy_a && t < 30000) begin @(negedge clk); t++; end
   endtask

   task automatic run_a(input logic c);
      @(negedge clk);
      cond_a = c; start_a = 1'b1; clr = 1'b1;
      @(negedge clk);
      start_a = 1'b0; clr = 1'b0;
      wait_idle_a();
   endtask

   typedef struct packed {
      logic       cond;
      logic       rd_err;
      logic [7:0] rd_data;
      logic       sr_err;
      logic       e_done;
      logic       e_on;
      logic       e_err;
      logic       e_sup;
      logic [1:0] e_nreq;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1}, // R5 full, unconditional
      '{1'b1, 1'b0, 8'h9C, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1}, // R7 bit7 ignored
      '{1'b1, 1'b0, 8'h1F, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1}, // R7 bits0,1 ignored
      '{1'b1, 1'b0, 8'h18, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2}, // R8 bit2 missing
      '{1'b1, 1'b1, 8'h1C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2}, // R8 read failed
      '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1}, // R9 soft reset failed
      '{1'b1, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2}, // R8 bit5 extra
      '{1'b1, 1'b0, 8'h1C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1}  // R7 exact match
   };

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 supply", int'(sup_a), 0);
      check("R11 rst line", int'(prn_a), 1);
      check("R11 busy/req", int'({busy_a, rv_a}), 0);
      check("R11 flags", int'({done_a, on_a, err_a}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 8; i++) begin
         cfg_rd_err  = VEC[i].rd_err;
         cfg_rd_data = VEC[i].rd_data;
         cfg_sr_err  = VEC[i].sr_err;
         run_a(VEC[i].cond);
         check($sformatf("R7 R8 R9 vec%0d done", i), int'(done_a), int'(VEC[i].e_done));
         check($sformatf("R7 vec%0d on_already", i), int'(on_a), int'(VEC[i].e_on));
         check($sformatf("R9 vec%0d err", i), int'(err_a), int'(VEC[i].e_err));
         check($sformatf("R1 vec%0d supply", i), int'(sup_a), int'(VEC[i].e_sup));
         check($sformatf("R8 vec%0d requests", i), nreq_a, int'(VEC[i].e_nreq));
         check($sformatf("R4 R6 vec%0d opcodes", i), opbad_a, 0);
         check($sformatf("R1 vec%0d supply first", i), supbad_a, 0);
         check($sformatf("R7 vec%0d pulse cycles", i), low_a,
               (VEC[i].e_nreq == 2'd2 || !VEC[i].cond) ? L_CYC : 0);
         if (i == 0) begin
            check("R2 pulse width", low_a, L_CYC);
            check("R3 hold before soft reset", hold_a, H_CYC);
            check("R5 settle with reset line", post_a, P_HW);
         end
      end

      // R10: start during hold-off is ignored
      cfg_rd_err = 1'b0; cfg_sr_err = 1'b0;
      @(negedge clk);
      cond_a = 1'b0; start_a = 1'b1; clr = 1'b1;
      @(negedge clk);
      start_a = 1'b0; clr = 1'b0;
      repeat (100) @(negedge clk);
      start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;
      wait_idle_a();
      check("R10 pulse not repeated", low_a, L_CYC);
      check("R10 hold not restarted", hold_a, H_CYC);
      check("R10 single request", nreq_a, 1);
      check("R10 done", int'(done_a), 1);

      // R5: no reset line, long settle
      @(negedge clk);
      start_b = 1'b1; clr = 1'b1;
      @(negedge clk);
      start_b = 1'b0; clr = 1'b0;
      begin
         int t = 0;
         @(negedge clk);
         while (busy_b && t < 30000) begin @(negedge clk); t++; end
      end
      check("R5 no-line settle", post_b, P_NR);
      check("R5 no-line rst stays high", low_b, 0);
      check("R5 no-line done", int'({done_b, on_b, err_b}), 4);
      check("R4 no-line request", nreq_b, 1);
      check("R4 no-line opcode", opbad_b, 0);
      check("R1 no-line supply", int'(sup_b), 1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule